// File: doc/BRIEF.md
# Receive Ring Writer

This block places received Ethernet frames, one after another, into a single circular byte region of memory that the host empties at its own pace. Each stored frame begins with a 32-bit header word that holds the frame's byte count and its completion status, and its data bytes follow directly. The next header always begins on a 4-byte boundary, and frame data that runs past the end of the region continues at offset 0.

Frames arrive through three strobes. A start strobe carries the declared length, one strobe per data byte follows, and an end strobe carries a bad-frame flag. When a frame is accepted, its header is first written with a length field of 0xFFF0. A host that sees this value knows the frame is still being written and stops reading. The real header is written when the end strobe arrives, and only then does the published write offset move forward. If the free space cannot hold the whole frame together with its header, the frame is discarded and a missed-frame counter advances.

The host writes its read position into a register as the true offset minus 16. The block corrects for this offset when it compares the two positions. It reports an empty flag, gives a one-cycle pulse for every committed header, and gives a separate pulse for frames committed without error. Memory is written through a 32-bit word port with byte enables.

Top module: `rxring_writer`

## Requirements
- R1: A final header word holds the byte count in bits 31:16, a receive-OK flag in bit 0 (set for a good frame), an error flag in bit 1 (set for a bad frame), and zero in bits 15:2. Byte offset k maps to word address k/4 and byte lane k mod 4, so storage is little-endian.
- R2: The cycle after an accepted start strobe, the header word at the write offset is written as 0xFFF00000. This happens before any data byte of that frame is written. The final header replaces it the cycle after the end strobe.
- R3: The count stored in the header is the number of data bytes stored, and the trailing 4 check bytes count as data. Bytes beyond the declared length are neither written nor counted.
- R4: On commit, the write offset W becomes (W + 4 + count) rounded up to a multiple of 4, modulo the ring size. The offset changes only on commit and is always a multiple of 4.
- R5: Data byte i of a frame whose header is at W is written to offset (W + 4 + i) modulo the ring size, so a frame can straddle the end of the ring.
- R6: A data byte write enables exactly one byte lane and places the byte in all four lanes of the data word. A header write enables all four lanes.
- R7: The read offset R is (host pointer + 16) modulo the ring size, and used = (W - R) modulo the ring size. A start strobe is accepted only if used + roundup4(length + 4) is less than the ring size. Otherwise nothing is written, the missed counter increments by one, and that frame's bytes and end strobe are ignored.
- R8: The receive-OK output pulses together with the commit pulse, and only for a frame whose end strobe had the bad flag low.
- R9: The commit output is a one-cycle pulse. It appears the cycle after the end strobe, together with the final header write. All write-port outputs are registered, one cycle after the strobe that causes them.
- R10: The empty output is high exactly when R equals the committed write offset.
- R11: A start strobe that arrives while a frame is being written is ignored. It neither restarts the frame nor counts as missed.
- R12: After reset, the write offset, the missed counter and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Frame start strobe |
| rx_len | input | 16 | Declared frame length (with check bytes), sampled with rx_start |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Data byte |
| rx_end | input | 1 | Frame end strobe |
| rx_bad | input | 1 | Frame received with error, sampled with rx_end |
| host_rd_ptr | input | 16 | Host read position minus 16 |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PTR_W-2 | Memory word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| wr_offset | output | PTR_W | Committed write offset in bytes |
| buf_empty | output | 1 | Host read offset equals write offset |
| hdr_commit | output | 1 | Final header committed (one cycle) |
| rx_ok | output | 1 | Committed frame was good (one cycle) |
| missed_cnt | output | MISS_W | Dropped-frame count |

## Verification
Short good and bad frames tell apart the status bit positions and the rounding of the next offset for different residues modulo 4. A frame that delivers more bytes than it declared, and a second start strobe in mid-frame, show that the declared length and the busy state control what gets stored. A series of 1500-byte frames that the host drains moves the write position until one frame straddles the end of the ring, which exercises the wrap of byte addresses. With the ring empty, lengths that would fill it exactly and lengths one word short, followed by zero-length frames against a ring with one word free, separate the strict space comparison from a non-strict one.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam logic [15:0] PENDING_LEN = 16'hFFF0;

    typedef enum logic {
        ST_IDLE,
        ST_FILL
    } fill_state_t;

    typedef struct packed {
        logic [15:0] len;
        logic [13:0] rsvd;
        logic        bad;
        logic        ok;
    } rx_hdr_t;

    function automatic rx_hdr_t make_hdr(input logic [15:0] count, input logic is_bad);
        rx_hdr_t h;
        h.len  = count;
        h.rsvd = '0;
        h.bad  = is_bad;
        h.ok   = ~is_bad;
        return h;
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] sel);
        return 4'b0001 << sel;
    endfunction

endpackage

// File: rtl/rxring_space.sv
module rxring_space #(
    parameter int RING_BYTES = 8192,
    parameter int PTR_W      = 13
) (
    input  logic [15:0]      host_rd_ptr,
    input  logic [PTR_W-1:0] wr_off,
    input  logic [15:0]      req_len,
    output logic             fits,
    output logic             is_empty
);
    localparam int SUM_W = 18;

    logic [PTR_W-1:0] rd_off;
    logic [PTR_W-1:0] used;
    logic [SUM_W-1:0] need;

    always_comb begin
        rd_off   = PTR_W'(host_rd_ptr + 16'd16);
        used     = wr_off - rd_off;
        need     = ({2'b00, req_len} + SUM_W'(7)) & ~SUM_W'(3);
        fits     = (SUM_W'(used) + need) < SUM_W'(RING_BYTES);
        is_empty = (rd_off == wr_off);
    end
endmodule

// File: rtl/rxring_memport.sv
module rxring_memport
    import rxring_pkg::*;
#(
    parameter int PTR_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             is_hdr,
    input  logic [PTR_W-1:0] off,
    input  logic [31:0]      hdr_word,
    input  logic [7:0]       data_in,
    output logic             we,
    output logic [PTR_W-3:0] addr,
    output logic [3:0]       be,
    output logic [31:0]      wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            we    <= 1'b0;
            addr  <= '0;
            be    <= '0;
            wdata <= '0;
        end else begin
            we <= req;
            if (req) begin
                addr  <= off[PTR_W-1:2];
                be    <= is_hdr ? 4'hF : lane_mask(off[1:0]);
                wdata <= is_hdr ? hdr_word : {4{data_in}};
            end
        end
    end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
    import rxring_pkg::*;
#(
    parameter int RING_BYTES = 8192,
    parameter int MISS_W     = 16,
    localparam int PTR_W     = $clog2(RING_BYTES),
    localparam int WA_W      = PTR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic [15:0]       rx_len,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              rx_bad,
    input  logic [15:0]       host_rd_ptr,
    output logic              mem_we,
    output logic [WA_W-1:0]   mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic [PTR_W-1:0]  wr_offset,
    output logic              buf_empty,
    output logic              hdr_commit,
    output logic              rx_ok,
    output logic [MISS_W-1:0] missed_cnt
);
    fill_state_t      state;
    logic [15:0]      frame_len;
    logic [15:0]      byte_cnt;
    logic [PTR_W-1:0] wr_off;

    logic             fits;
    logic             take_start, drop_start, do_byte, do_end;
    logic             port_req, port_hdr;
    logic [PTR_W-1:0] byte_pos, port_off, next_off;
    logic [31:0]      hdr_word;

    rxring_space #(.RING_BYTES(RING_BYTES), .PTR_W(PTR_W)) i_space (
        .host_rd_ptr (host_rd_ptr),
        .wr_off      (wr_off),
        .req_len     (rx_len),
        .fits        (fits),
        .is_empty    (buf_empty)
    );

    always_comb begin
        take_start = (state == ST_IDLE) && rx_start && fits;
        drop_start = (state == ST_IDLE) && rx_start && !fits;
        do_end     = (state == ST_FILL) && rx_end;
        do_byte    = (state == ST_FILL) && !rx_end && rx_valid && (byte_cnt < frame_len);
        byte_pos   = wr_off + PTR_W'(4) + byte_cnt[PTR_W-1:0];
        next_off   = (wr_off + PTR_W'(7) + byte_cnt[PTR_W-1:0]) & ~PTR_W'(3);
        hdr_word   = do_end ? 32'(make_hdr(byte_cnt, rx_bad)) : {PENDING_LEN, 16'h0000};
        port_hdr   = take_start || do_end;
        port_req   = port_hdr || do_byte;
        port_off   = port_hdr ? wr_off : byte_pos;
    end

    rxring_memport #(.PTR_W(PTR_W)) i_port (
        .clk      (clk),
        .rst      (rst),
        .req      (port_req),
        .is_hdr   (port_hdr),
        .off      (port_off),
        .hdr_word (hdr_word),
        .data_in  (rx_data),
        .we       (mem_we),
        .addr     (mem_addr),
        .be       (mem_be),
        .wdata    (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            frame_len  <= '0;
            byte_cnt   <= '0;
            wr_off     <= '0;
            missed_cnt <= '0;
            hdr_commit <= 1'b0;
            rx_ok      <= 1'b0;
        end else begin
            hdr_commit <= do_end;
            rx_ok      <= do_end && !rx_bad;
            if (take_start) begin
                state     <= ST_FILL;
                frame_len <= rx_len;
                byte_cnt  <= '0;
            end
            if (drop_start) missed_cnt <= missed_cnt + MISS_W'(1);
            if (do_byte)    byte_cnt   <= byte_cnt + 16'd1;
            if (do_end) begin
                state  <= ST_IDLE;
                wr_off <= next_off;
            end
        end
    end

    assign wr_offset = wr_off;
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
    parameter int PTR_W  = 13,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic [PTR_W-1:0]  wr_offset,
    input logic              hdr_commit,
    input logic              rx_ok,
    input logic [MISS_W-1:0] missed_cnt
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    AST_OFF_ALIGNED: assert property (@(posedge clk) disable iff (rst || !armed)
        wr_offset[1:0] == 2'b00);                                               // R4
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
        !hdr_commit |-> $stable(wr_offset));                                    // R4
    AST_FINAL_HDR: assert property (@(posedge clk) disable iff (rst || !armed)
        hdr_commit |-> (mem_we && mem_be == 4'hF && mem_wdata[31:16] != 16'hFFF0)); // R2
    AST_HDR_STATUS: assert property (@(posedge clk) disable iff (rst || !armed)
        hdr_commit |-> (mem_wdata[15:2] == 14'd0 && $onehot(mem_wdata[1:0]))); // R1
    AST_OK_WITH_COMMIT: assert property (@(posedge clk) disable iff (rst || !armed)
        rx_ok |-> (hdr_commit && mem_wdata[0]));                                // R8
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst || !armed)
        hdr_commit |=> !hdr_commit);                                            // R9
    AST_LANES: assert property (@(posedge clk) disable iff (rst || !armed)
        mem_we |-> (mem_be == 4'hF || $countones(mem_be) == 1));                // R6
    AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst || !armed)
        (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == $past(missed_cnt) + MISS_W'(1))); // R7
endmodule

bind rxring_writer rxring_writer_chk #(.PTR_W(PTR_W), .MISS_W(MISS_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .wr_offset  (wr_offset),
    .hdr_commit (hdr_commit),
    .rx_ok      (rx_ok),
    .missed_cnt (missed_cnt)
);

// File: tb/test_rxring_writer.sv
`timescale 1ns/1ps
module test_rxring_writer;
    localparam int N  = 8192;
    localparam int PW = 13;

    logic clk = 0;
    logic rst = 1;
    logic rx_start = 0, rx_valid = 0, rx_end = 0, rx_bad = 0;
    logic [15:0] rx_len = 0;
    logic [7:0]  rx_data = 0;
    logic [15:0] host_rd_ptr = 16'hFFF0;
    logic        mem_we;
    logic [PW-3:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [PW-1:0] wr_offset;
    logic        buf_empty, hdr_commit, rx_ok;
    logic [15:0] missed_cnt;

    always #2 clk = ~clk;

    rxring_writer #(.RING_BYTES(N), .MISS_W(16)) i_rxring_writer (
        .clk(clk), .rst(rst), .rx_start(rx_start), .rx_len(rx_len), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .rx_bad(rx_bad), .host_rd_ptr(host_rd_ptr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .wr_offset(wr_offset), .buf_empty(buf_empty), .hdr_commit(hdr_commit),
        .rx_ok(rx_ok), .missed_cnt(missed_cnt)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit good, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_w = 0, m_len = 0, m_cnt = 0, m_miss = 0;
    bit m_busy = 0;
    bit e_we = 0, e_commit = 0, e_ok = 0;
    int e_addr = 0;
    logic [3:0]  e_be = 0;
    logic [31:0] e_data = 0;
    int r_off, used, need, pos;

    always @(posedge clk) begin
        if (rst) begin
            m_w = 0; m_len = 0; m_cnt = 0; m_miss = 0; m_busy = 0;
            e_we = 0; e_commit = 0; e_ok = 0;
        end else begin
            e_we = 0; e_commit = 0; e_ok = 0;
            if (!m_busy && rx_start) begin
                r_off = (int'(host_rd_ptr) + 16) % N;
                used  = (m_w - r_off + N) % N;
                need  = ((int'(rx_len) + 7) / 4) * 4;
                if (used + need < N) begin
                    m_busy = 1; m_len = int'(rx_len); m_cnt = 0;
                    e_we = 1; e_addr = m_w / 4; e_be = 4'hF; e_data = 32'hFFF0_0000;
                end else begin
                    m_miss = (m_miss + 1) % 65536;
                end
            end else if (m_busy && rx_end) begin
                e_we = 1; e_addr = m_w / 4; e_be = 4'hF;
                e_data = {m_cnt[15:0], 14'd0, rx_bad, !rx_bad};
                e_commit = 1; e_ok = !rx_bad;
                m_w = (((m_w + 4 + m_cnt + 3) / 4) * 4) % N;
                m_busy = 0;
            end else if (m_busy && rx_valid && m_cnt < m_len) begin
                pos = (m_w + 4 + m_cnt) % N;
                e_we = 1; e_addr = pos / 4; e_be = 4'b0001 << (pos % 4);
                e_data = {4{rx_data}};
                m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(mem_we === e_we, "R9 write strobe", mem_we, e_we);
            if (e_we) begin
                chk(int'(mem_addr) == e_addr, "R5 word address", mem_addr, e_addr);
                chk(mem_be === e_be, "R6 lane enables", mem_be, e_be);
                chk(mem_wdata === e_data, "R1 write data", mem_wdata, e_data);
            end
            chk(hdr_commit === e_commit, "R9 commit pulse", hdr_commit, e_commit);
            chk(rx_ok === e_ok, "R8 receive ok", rx_ok, e_ok);
            chk(int'(wr_offset) == m_w, "R4 write offset", wr_offset, m_w);
            chk(buf_empty === (((int'(host_rd_ptr) + 16) % N) == m_w), "R10 empty",
                buf_empty, (((int'(host_rd_ptr) + 16) % N) == m_w));
            chk(int'(missed_cnt) == m_miss, "R7 missed count", missed_cnt, m_miss);
        end
    end

    // captured memory image
    logic [7:0] img [N];
    initial for (int i = 0; i < N; i++) img[i] = 8'h00;
    always @(posedge clk) begin
        if (mem_we) begin
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) img[int'(mem_addr) * 4 + l] = mem_wdata[8*l +: 8];
        end
    end

    function automatic logic [31:0] rd32(input int off);
        return {img[off+3], img[off+2], img[off+1], img[off]};
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 7 + 3) & 255);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input int decl, input int nbytes, input bit bad, input int seed);
        rx_start = 1; rx_len = 16'(decl);
        step();
        rx_start = 0;
        for (int i = 0; i < nbytes; i++) begin
            rx_valid = 1; rx_data = pat(seed, i);
            step();
        end
        rx_valid = 0; rx_end = 1; rx_bad = bad;
        step();
        rx_end = 0; rx_bad = 0;
        step();
    endtask

    task automatic drain();
        host_rd_ptr = 16'((m_w - 16) & 16'hFFFF);
        step();
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    int w0, w1, mbase;

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R12 reset state
        chk(mem_we == 0, "R12 reset write strobe", mem_we, 0);
        chk(wr_offset == 0, "R12 reset offset", wr_offset, 0);
        chk(missed_cnt == 0, "R12 reset missed", missed_cnt, 0);
        chk(hdr_commit == 0 && rx_ok == 0, "R12 reset pulses", {hdr_commit, rx_ok}, 0);
        chk(buf_empty == 1, "R10 reset empty", buf_empty, 1);
        rst = 0;
        step();

        // good short frame, with explicit placeholder check (R2)
        rx_start = 1; rx_len = 16'd10;
        step();
        rx_start = 0;
        chk(mem_we && mem_wdata == 32'hFFF0_0000 && mem_addr == 0, "R2 placeholder",
            mem_wdata, 32'hFFF0_0000);
        for (int i = 0; i < 10; i++) begin
            rx_valid = 1; rx_data = pat(1, i);
            step();
        end
        rx_valid = 0; rx_end = 1;
        step();
        rx_end = 0;
        chk(hdr_commit && rx_ok, "R9 commit after end", {hdr_commit, rx_ok}, 3);
        step();
        chk(rd32(0) == {16'd10, 16'h0001}, "R1 good header", rd32(0), {16'd10, 16'h0001});
        chk(img[4] == pat(1, 0) && img[13] == pat(1, 9), "R5 frame bytes", img[13], pat(1, 9));
        chk(wr_offset == 16, "R4 round offset", wr_offset, 16);
        chk(buf_empty == 0, "R10 not empty", buf_empty, 0);

        // bad frame
        send_frame(7, 7, 1, 2);
        chk(rd32(16) == {16'd7, 16'h0002}, "R1 bad header", rd32(16), {16'd7, 16'h0002});
        chk(wr_offset == 28, "R4 round offset bad", wr_offset, 28);
        drain();
        chk(buf_empty == 1, "R10 empty after drain", buf_empty, 1);

        // more bytes than declared
        send_frame(5, 8, 0, 3);
        chk(rd32(28) == {16'd5, 16'h0001}, "R3 declared length caps", rd32(28), {16'd5, 16'h0001});
        chk(img[37] == 8'h00, "R3 extra byte discarded", img[37], 0);
        chk(wr_offset == 40, "R4 offset after capped frame", wr_offset, 40);

        // start while busy
        rx_start = 1; rx_len = 16'd6;
        step();
        rx_start = 0;
        for (int i = 0; i < 3; i++) begin rx_valid = 1; rx_data = pat(4, i); step(); end
        rx_valid = 0; rx_start = 1; rx_len = 16'd20;
        step();
        rx_start = 0;
        for (int i = 3; i < 6; i++) begin rx_valid = 1; rx_data = pat(4, i); step(); end
        rx_valid = 0; rx_end = 1;
        step();
        rx_end = 0;
        step();
        chk(rd32(40) == {16'd6, 16'h0001}, "R11 second start ignored", rd32(40), {16'd6, 16'h0001});
        chk(missed_cnt == 0, "R11 not counted missed", missed_cnt, 0);
        chk(img[49] == pat(4, 5), "R11 bytes continue", img[49], pat(4, 5));
        drain();

        // wrap: fill with drained frames until one straddles the end
        while (m_w + 4 + 1500 <= N) begin
            send_frame(1500, 1500, 0, 5);
            drain();
        end
        w0 = m_w;
        send_frame(1500, 1500, 0, 6);
        chk(rd32(w0) == {16'd1500, 16'h0001}, "R5 straddling header", rd32(w0), {16'd1500, 16'h0001});
        chk(img[N - 1] == pat(6, N - 1 - w0 - 4), "R5 last byte before wrap",
            img[N - 1], pat(6, N - 1 - w0 - 4));
        chk(img[0] == pat(6, N - w0 - 4), "R5 first byte after wrap", img[0], pat(6, N - w0 - 4));
        chk(img[(w0 + 4 + 1499) % N] == pat(6, 1499), "R5 tail after wrap",
            img[(w0 + 4 + 1499) % N], pat(6, 1499));
        chk(int'(wr_offset) == (w0 + 1504) % N, "R4 offset wraps", wr_offset, (w0 + 1504) % N);
        drain();

        // space boundaries
        w1 = m_w;
        send_frame(N - 4, 3, 0, 7);
        chk(missed_cnt == 1, "R7 exact fill dropped", missed_cnt, 1);
        chk(int'(wr_offset) == w1, "R7 drop leaves offset", wr_offset, w1);
        chk(rd32(w1) != 32'hFFF0_0000, "R7 drop writes nothing", rd32(w1), 0);
        send_frame(N - 8, N - 8, 0, 8);
        chk(missed_cnt == 1, "R7 one word short accepted", missed_cnt, 1);
        chk(int'(wr_offset) == (w1 + N - 4) % N, "R4 offset after big frame",
            wr_offset, (w1 + N - 4) % N);
        mbase = m_w;
        send_frame(0, 0, 0, 9);
        chk(missed_cnt == 2, "R7 zero frame into one free word dropped", missed_cnt, 2);
        drain();
        send_frame(0, 0, 0, 10);
        chk(rd32(mbase) == {16'd0, 16'h0001}, "R1 zero-length header", rd32(mbase), 32'h1);
        chk(int'(wr_offset) == (mbase + 4) % N, "R4 zero-length advance", wr_offset, (mbase + 4) % N);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule